// File: doc/BRIEF.md
# Hit Sub-Bin Grouper with Plane Sorter

This block takes the time-stamped hit words that a detector front end produces during one 25 ns bin of a 40 MHz clock. It collects the hits that lie close together in time into candidate events, called sub-bin groups. Each hit carries a fine time inside the bin, counted in 100 ps ticks, so a 5 ns window is 50 ticks. A hit that lies well inside the window of the group's first hit joins that group. A hit in the outer band, between one and two windows from the first hit, stays pending until the next usable hit arrives. It then goes to whichever neighbour is nearer in time. A group whose window runs past the end of the bin claims the start of the following bin, and hits in that claimed span are discarded.

Each accepted hit is filed into a vertical or a horizontal list according to the front-end converter that produced it. A group that closes is presented for one cycle with both lists, their counts and an overflow flag. Words arrive over a valid/ready handshake, and the upstream source marks the final word of each bin. After that final word the block spends exactly one cycle closing the bin.

Top module: `hit_subbin_sorter`

## Requirements
- R1: After reset, `out_valid` is low and `in_ready` is high.
- R2: A usable hit whose time is less than `TMAX_TICKS` after the opening hit of the open group joins that group.
- R3: A usable hit that is at least 2·`TMAX_TICKS` after the opening hit closes the open group, and the closed group is presented in the cycle after that hit is accepted. The closing hit opens a new group.
- R4: A hit between `TMAX_TICKS` and 2·`TMAX_TICKS` after the opening hit is held back. When the next usable hit arrives, the held hit joins the open group if its distance to that group's latest member is no larger than its distance to the new hit. Otherwise the open group closes and the held hit opens a new group.
- R5: A hit still held back when the bin ends joins the open group.
- R6: The converter identifier is bits [8:5] of the word. Values 0 and 1 go to the vertical list and values 2 and 3 go to the horizontal list. Words carrying any other value are dropped.
- R7: Bit 9 is the edge type: 1 for a leading edge, 0 for a trailing edge. Trailing-edge words are dropped and have no effect on grouping.
- R8: Suppose the last group of a bin opened at time s, and s + `TMAX_TICKS` exceeds `BIN_TICKS`. Then hits in the next bin with a time below s + `TMAX_TICKS` − `BIN_TICKS` are dropped. The claim covers only that one bin.
- R9: Each list holds at most `MAX_HITS` words. A further hit for a full list is dropped, that list's count stays at `MAX_HITS`, and `out_ovf` is set for the group.
- R10: Once a word with `in_last` set is accepted, `in_ready` is low for exactly one cycle. At the end of that cycle, any open group is presented.
- R11: Within each list, slot 0 holds the earliest member and members follow in arrival order. Each word is bits [17:10] fine time, bit 9 edge, bits [8:5] converter, bits [4:0] channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Hit word is offered |
| in_word | input | 18 | Hit word: fine time, edge, converter id, channel |
| in_last | input | 1 | Offered word is the final one of the bin |
| in_ready | output | 1 | Block accepts a word this cycle |
| out_valid | output | 1 | One-cycle strobe: a completed group is presented |
| out_vert_hits | output | MAX_HITS·18 | Vertical-plane words, slot i at bits [18i+17:18i] |
| out_vert_cnt | output | clog2(MAX_HITS+1) | Number of vertical words in the group |
| out_horz_hits | output | MAX_HITS·18 | Horizontal-plane words, same slot layout |
| out_horz_cnt | output | clog2(MAX_HITS+1) | Number of horizontal words in the group |
| out_ovf | output | 1 | A list of the group filled and later hits were dropped |

## Verification
The block assumes that the words of one bin arrive in non-decreasing fine-time order and that no time exceeds `BIN_TICKS`−1. The window tests and the nearest-neighbour choice are only meaningful under that ordering. Every directed scenario builds its words with ascending times below 250 and ends each bin with a word flagged `in_last`. The scenarios place hits exactly on the window edges, the claim boundary and the list capacity, so that each decision is taken on both of its sides.

// File: rtl/hit_sorter_pkg.sv
package hit_sorter_pkg;

    localparam int TIME_W   = 8;
    localparam int CHAN_W   = 5;
    localparam int TDC_W    = 4;
    localparam int TDC_LSB  = CHAN_W;
    localparam int EDGE_BIT = TDC_LSB + TDC_W;
    localparam int TIME_LSB = EDGE_BIT + 1;
    localparam int HIT_W    = TIME_LSB + TIME_W;

    typedef enum logic [1:0] {
        WIN_NEAR,
        WIN_MID,
        WIN_FAR
    } win_cls_e;

    typedef enum logic {
        MODE_RUN,
        MODE_FLUSH
    } mode_e;

    function automatic logic [TIME_W-1:0] hit_time(input logic [HIT_W-1:0] w);
        return w[TIME_LSB +: TIME_W];
    endfunction

    function automatic logic hit_is_vert(input logic [HIT_W-1:0] w);
        return w[TDC_LSB +: TDC_W] < TDC_W'(2);
    endfunction

    function automatic logic [TIME_W:0] hit_gap(input logic [TIME_W-1:0] ref_t,
                                                input logic [TIME_W-1:0] hit_t);
        return (hit_t >= ref_t) ? ({1'b0, hit_t} - {1'b0, ref_t}) : '0;
    endfunction

endpackage

// File: rtl/hg_hit_decode.sv
module hg_hit_decode
    import hit_sorter_pkg::*;
(
    input  logic [TIME_W-1:0] hit_t,
    input  logic              edge_lead,
    input  logic [TDC_W-1:0]  tdc_id,
    input  logic [TIME_W-1:0] claim_end,
    output logic              usable
);
    logic known_tdc;
    logic claimed;

    always_comb begin
        known_tdc = tdc_id < TDC_W'(4);
        claimed   = hit_t < claim_end;
        usable    = edge_lead && known_tdc && !claimed;
    end
endmodule

// File: rtl/hg_window_judge.sv
module hg_window_judge
    import hit_sorter_pkg::*;
#(
    parameter int TMAX_TICKS = 50
) (
    input  logic [TIME_W-1:0] ref_t,
    input  logic [TIME_W-1:0] hit_t,
    output win_cls_e          cls
);
    logic [TIME_W:0] gap;

    always_comb begin
        gap = hit_gap(ref_t, hit_t);
        if (int'(gap) < TMAX_TICKS) begin
            cls = WIN_NEAR;
        end else if (int'(gap) < 2 * TMAX_TICKS) begin
            cls = WIN_MID;
        end else begin
            cls = WIN_FAR;
        end
    end
endmodule

// File: rtl/hit_subbin_sorter.sv
module hit_subbin_sorter
    import hit_sorter_pkg::*;
#(
    parameter int TMAX_TICKS = 50,
    parameter int BIN_TICKS  = 250,
    parameter int MAX_HITS   = 8,
    localparam int CNT_W     = $clog2(MAX_HITS + 1),
    localparam int IDX_W     = $clog2(MAX_HITS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic [HIT_W-1:0]          in_word,
    input  logic                      in_last,
    output logic                      in_ready,
    output logic                      out_valid,
    output logic [MAX_HITS*HIT_W-1:0] out_vert_hits,
    output logic [CNT_W-1:0]          out_vert_cnt,
    output logic [MAX_HITS*HIT_W-1:0] out_horz_hits,
    output logic [CNT_W-1:0]          out_horz_cnt,
    output logic                      out_ovf
);

    typedef struct packed {
        logic [MAX_HITS-1:0][HIT_W-1:0] v_hits;
        logic [CNT_W-1:0]               v_cnt;
        logic [MAX_HITS-1:0][HIT_W-1:0] h_hits;
        logic [CNT_W-1:0]               h_cnt;
        logic                           ovf;
    } grp_t;

    typedef struct packed {
        mode_e             mode;
        logic              open;
        grp_t              grp;
        logic [TIME_W-1:0] start_t;
        logic [TIME_W-1:0] last_t;
        logic              pend_v;
        logic [HIT_W-1:0]  pend_word;
        logic [TIME_W-1:0] claim_end;
        logic              out_valid;
        grp_t              out_grp;
    } state_t;

    state_t d, q;

    function automatic grp_t push_hit(input grp_t g, input logic [HIT_W-1:0] w);
        grp_t r;
        r = g;
        if (hit_is_vert(w)) begin
            if (r.v_cnt == CNT_W'(MAX_HITS)) begin
                r.ovf = 1'b1;
            end else begin
                r.v_hits[IDX_W'(r.v_cnt)] = w;
                r.v_cnt = r.v_cnt + 1'b1;
            end
        end else begin
            if (r.h_cnt == CNT_W'(MAX_HITS)) begin
                r.ovf = 1'b1;
            end else begin
                r.h_hits[IDX_W'(r.h_cnt)] = w;
                r.h_cnt = r.h_cnt + 1'b1;
            end
        end
        return r;
    endfunction

    logic [TIME_W-1:0] h_t;
    logic [TIME_W-1:0] p_t;
    logic              hit_ok;
    win_cls_e          cls_grp;
    win_cls_e          cls_pend;
    logic [TIME_W:0]   gap_last;
    logic [TIME_W:0]   gap_pend;
    logic [TIME_W+1:0] reach_t;
    grp_t              joined;

    assign h_t      = hit_time(in_word);
    assign p_t      = hit_time(q.pend_word);
    assign gap_last = hit_gap(q.last_t, p_t);
    assign gap_pend = hit_gap(p_t, h_t);
    assign reach_t  = {2'b00, q.start_t} + (TIME_W+2)'(TMAX_TICKS);
    assign joined   = push_hit(q.grp, q.pend_word);

    hg_hit_decode i_decode (
        .hit_t     (h_t),
        .edge_lead (in_word[EDGE_BIT]),
        .tdc_id    (in_word[TDC_LSB +: TDC_W]),
        .claim_end (q.claim_end),
        .usable    (hit_ok)
    );

    hg_window_judge #(.TMAX_TICKS(TMAX_TICKS)) i_judge_grp (
        .ref_t (q.start_t),
        .hit_t (h_t),
        .cls   (cls_grp)
    );

    hg_window_judge #(.TMAX_TICKS(TMAX_TICKS)) i_judge_pend (
        .ref_t (p_t),
        .hit_t (h_t),
        .cls   (cls_pend)
    );

    always_comb begin
        d           = q;
        d.out_valid = 1'b0;
        in_ready    = (q.mode == MODE_RUN);

        if (q.mode == MODE_RUN) begin
            if (in_valid) begin
                if (hit_ok) begin
                    if (!q.open) begin
                        d.grp     = push_hit('0, in_word);
                        d.start_t = h_t;
                        d.last_t  = h_t;
                        d.open    = 1'b1;
                    end else if (!q.pend_v) begin
                        unique case (cls_grp)
                            WIN_NEAR: begin
                                d.grp    = push_hit(q.grp, in_word);
                                d.last_t = h_t;
                            end
                            WIN_MID: begin
                                d.pend_v    = 1'b1;
                                d.pend_word = in_word;
                            end
                            default: begin
                                d.out_grp   = q.grp;
                                d.out_valid = 1'b1;
                                d.grp       = push_hit('0, in_word);
                                d.start_t   = h_t;
                                d.last_t    = h_t;
                            end
                        endcase
                    end else if (gap_last <= gap_pend) begin
                        if (cls_grp == WIN_FAR) begin
                            d.out_grp   = joined;
                            d.out_valid = 1'b1;
                            d.grp       = push_hit('0, in_word);
                            d.start_t   = h_t;
                            d.last_t    = h_t;
                            d.pend_v    = 1'b0;
                        end else begin
                            d.grp       = joined;
                            d.last_t    = p_t;
                            d.pend_word = in_word;
                        end
                    end else begin
                        d.out_grp   = q.grp;
                        d.out_valid = 1'b1;
                        d.start_t   = p_t;
                        if (cls_pend == WIN_NEAR) begin
                            d.grp    = push_hit(push_hit('0, q.pend_word), in_word);
                            d.last_t = h_t;
                            d.pend_v = 1'b0;
                        end else begin
                            d.grp       = push_hit('0, q.pend_word);
                            d.last_t    = p_t;
                            d.pend_word = in_word;
                        end
                    end
                end
                if (in_last) begin
                    d.mode = MODE_FLUSH;
                end
            end
        end else begin
            d.mode      = MODE_RUN;
            d.claim_end = '0;
            if (q.open) begin
                d.out_grp   = q.pend_v ? joined : q.grp;
                d.out_valid = 1'b1;
                if (reach_t > (TIME_W+2)'(BIN_TICKS)) begin
                    d.claim_end = TIME_W'(reach_t - (TIME_W+2)'(BIN_TICKS));
                end
            end
            d.open   = 1'b0;
            d.pend_v = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign out_valid     = q.out_valid;
    assign out_vert_hits = q.out_grp.v_hits;
    assign out_vert_cnt  = q.out_grp.v_cnt;
    assign out_horz_hits = q.out_grp.h_hits;
    assign out_horz_cnt  = q.out_grp.h_cnt;
    assign out_ovf       = q.out_grp.ovf;

endmodule

module hit_subbin_sorter_chk
    import hit_sorter_pkg::*;
#(
    parameter int MAX_HITS = 8,
    localparam int CNT_W   = $clog2(MAX_HITS + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_last,
    input logic             in_ready,
    input logic             out_valid,
    input logic [CNT_W-1:0] out_vert_cnt,
    input logic [CNT_W-1:0] out_horz_cnt,
    input logic             out_ovf,
    input logic [TDC_W-1:0] v_tdc0,
    input logic [TDC_W-1:0] h_tdc0,
    input logic             v_edge0
);
    AST_FLUSH_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_last) |=> !in_ready); // R10
    AST_FLUSH_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |=> in_ready); // R10
    AST_GROUP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_vert_cnt != '0) || (out_horz_cnt != '0)); // R2
    AST_VERT_PLANE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_vert_cnt != '0) |-> v_tdc0 < TDC_W'(2)); // R6
    AST_HORZ_PLANE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_horz_cnt != '0) |-> (v_tdc0 == v_tdc0) && (h_tdc0 == TDC_W'(2) || h_tdc0 == TDC_W'(3))); // R6
    AST_LEADING_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_vert_cnt != '0) |-> v_edge0); // R7
    AST_OVF_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ovf) |-> (out_vert_cnt == CNT_W'(MAX_HITS)) || (out_horz_cnt == CNT_W'(MAX_HITS))); // R9
    AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_vert_cnt <= CNT_W'(MAX_HITS)) && (out_horz_cnt <= CNT_W'(MAX_HITS))); // R9
endmodule

bind hit_subbin_sorter hit_subbin_sorter_chk #(.MAX_HITS(MAX_HITS)) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_last      (in_last),
    .in_ready     (in_ready),
    .out_valid    (out_valid),
    .out_vert_cnt (out_vert_cnt),
    .out_horz_cnt (out_horz_cnt),
    .out_ovf      (out_ovf),
    .v_tdc0       (out_vert_hits[hit_sorter_pkg::TDC_LSB +: hit_sorter_pkg::TDC_W]),
    .h_tdc0       (out_horz_hits[hit_sorter_pkg::TDC_LSB +: hit_sorter_pkg::TDC_W]),
    .v_edge0      (out_vert_hits[hit_sorter_pkg::EDGE_BIT])
);

// File: tb/test_hit_subbin_sorter.sv
module test_hit_subbin_sorter;

    localparam int W   = 18;
    localparam int MAX = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           in_valid = 1'b0;
    logic [W-1:0]   in_word = '0;
    logic           in_last = 1'b0;
    logic           in_ready;
    logic           out_valid;
    logic [MAX*W-1:0] out_vert_hits;
    logic [3:0]     out_vert_cnt;
    logic [MAX*W-1:0] out_horz_hits;
    logic [3:0]     out_horz_cnt;
    logic           out_ovf;

    int n_checks = 0;
    int n_fail   = 0;
    int cap_n    = 0;
    int base     = 0;
    logic rdy_seen;
    logic ov_seen;

    logic [MAX*W-1:0] cap_v [64];
    logic [MAX*W-1:0] cap_h [64];
    int               cap_vc [64];
    int               cap_hc [64];
    int               cap_ovf [64];

    always #2.5 clk = ~clk;

    hit_subbin_sorter i_hit_subbin_sorter (
        .clk           (clk),
        .rst_n         (rst_n),
        .in_valid      (in_valid),
        .in_word       (in_word),
        .in_last       (in_last),
        .in_ready      (in_ready),
        .out_valid     (out_valid),
        .out_vert_hits (out_vert_hits),
        .out_vert_cnt  (out_vert_cnt),
        .out_horz_hits (out_horz_hits),
        .out_horz_cnt  (out_horz_cnt),
        .out_ovf       (out_ovf)
    );

    always @(negedge clk) begin
        if (rst_n && out_valid && cap_n < 64) begin
            cap_v[cap_n]   <= out_vert_hits;
            cap_h[cap_n]   <= out_horz_hits;
            cap_vc[cap_n]  <= int'(out_vert_cnt);
            cap_hc[cap_n]  <= int'(out_horz_cnt);
            cap_ovf[cap_n] <= int'(out_ovf);
            cap_n          <= cap_n + 1;
        end
    end

    function automatic logic [W-1:0] mk(int tdc, int ch, int t, bit lead);
        logic [W-1:0] w;
        w[4:0]   = ch[4:0];
        w[8:5]   = tdc[3:0];
        w[9]     = lead;
        w[17:10] = t[7:0];
        return w;
    endfunction

    function automatic int slot_t(logic [MAX*W-1:0] v, int i);
        return int'(v[i*W+10 +: 8]);
    endfunction

    task automatic chk(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic send(int tdc, int t, bit lead, bit last);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1;
        in_word  = mk(tdc, t % 32, t, lead);
        in_last  = last;
        @(posedge clk);
        @(negedge clk);
        rdy_seen = in_ready;
        ov_seen  = out_valid;
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 out_valid after reset", int'(out_valid), 0);
        chk("R1 in_ready after reset", int'(in_ready), 1);
        base = cap_n;
    endtask

    task automatic t_basic();
        do_reset();
        send(0, 10, 1, 0);
        send(2, 20, 1, 0);
        send(1, 40, 1, 0);
        send(3, 55, 1, 1);
        chk("R10 ready low after last", int'(rdy_seen), 0);
        chk("R10 no group before flush", int'(ov_seen), 0);
        @(negedge clk);
        chk("R10 ready back after flush", int'(in_ready), 1);
        settle();
        chk("R2 one group", cap_n - base, 1);
        chk("R6 vertical count", cap_vc[base], 2);
        chk("R6 horizontal count", cap_hc[base], 2);
        chk("R11 vert slot0", slot_t(cap_v[base], 0), 10);
        chk("R11 vert slot1", slot_t(cap_v[base], 1), 40);
        chk("R11 horz slot0", slot_t(cap_h[base], 0), 20);
        chk("R2 horz slot1 near edge", slot_t(cap_h[base], 1), 55);
        chk("R9 no overflow", cap_ovf[base], 0);
    endtask

    task automatic t_far();
        do_reset();
        send(0, 10, 1, 0);
        send(5, 15, 1, 0);
        send(1, 120, 1, 1);
        chk("R3 group out after closing hit", int'(ov_seen), 1);
        settle();
        chk("R3 two groups", cap_n - base, 2);
        chk("R6 unknown id dropped", cap_vc[base], 1);
        chk("R6 unknown id not horizontal", cap_hc[base], 0);
        chk("R3 second group opener", slot_t(cap_v[base+1], 0), 120);
    endtask

    task automatic t_mid_join();
        do_reset();
        send(0, 10, 1, 0);
        send(0, 30, 1, 0);
        send(2, 70, 1, 0);
        send(1, 130, 1, 1);
        settle();
        chk("R4 join: groups", cap_n - base, 2);
        chk("R4 join: vert", cap_vc[base], 2);
        chk("R4 join: horz", cap_hc[base], 1);
        chk("R4 join: horz time", slot_t(cap_h[base], 0), 70);
        chk("R4 join: next group", slot_t(cap_v[base+1], 0), 130);
    endtask

    task automatic t_mid_split();
        do_reset();
        send(0, 10, 1, 0);
        send(2, 70, 1, 0);
        send(1, 90, 1, 1);
        settle();
        chk("R4 split: groups", cap_n - base, 2);
        chk("R4 split: first horz", cap_hc[base], 0);
        chk("R4 split: second vert", cap_vc[base+1], 1);
        chk("R4 split: second horz", cap_hc[base+1], 1);
        chk("R4 split: held hit leads", slot_t(cap_h[base+1], 0), 70);
    endtask

    task automatic t_mid_end();
        do_reset();
        send(0, 10, 1, 0);
        send(3, 75, 1, 1);
        settle();
        chk("R5 groups", cap_n - base, 1);
        chk("R5 held hit joined", cap_hc[base], 1);
        chk("R5 held hit time", slot_t(cap_h[base], 0), 75);
    endtask

    task automatic t_trail();
        do_reset();
        send(0, 10, 1, 0);
        send(0, 20, 0, 0);
        send(1, 30, 1, 1);
        settle();
        chk("R7 trailing dropped count", cap_vc[base], 2);
        chk("R7 slot1 is leading hit", slot_t(cap_v[base], 1), 30);
    endtask

    task automatic t_carry();
        do_reset();
        send(0, 230, 1, 1);
        settle();
        send(0, 20, 1, 0);
        send(1, 30, 1, 0);
        send(2, 40, 1, 1);
        settle();
        send(0, 10, 1, 1);
        settle();
        chk("R8 groups", cap_n - base, 3);
        chk("R8 claimed hit dropped", cap_vc[base+1], 1);
        chk("R8 hit on boundary kept", slot_t(cap_v[base+1], 0), 30);
        chk("R8 horz kept", cap_hc[base+1], 1);
        chk("R8 claim spans one bin", slot_t(cap_v[base+2], 0), 10);
    endtask

    task automatic t_ovf();
        do_reset();
        for (int i = 0; i < 10; i++) begin
            send(i % 2, i, 1, 0);
            if (i == 5) send(2, 5, 1, 0);
        end
        send(7, 12, 1, 1);
        settle();
        chk("R9 groups", cap_n - base, 1);
        chk("R9 vert saturates", cap_vc[base], MAX);
        chk("R9 horz unaffected", cap_hc[base], 1);
        chk("R9 overflow flag", cap_ovf[base], 1);
        chk("R9 last kept slot", slot_t(cap_v[base], MAX-1), 7);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        t_basic();
        t_far();
        t_mid_join();
        t_mid_split();
        t_mid_end();
        t_trail();
        t_carry();
        t_ovf();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule